// File: doc/BRIEF.md
# Write Strobe Window Center Calculator

This block turns the outcome of a write-strobe edge search into a single target delay tap. Four edge markers are reported by the search. Each marker has a found flag and a tap value. The markers are: the noise-to-zero edge, the zero-to-noise edge, the noise-to-half-cycle edge and the half-cycle-to-noise edge. The search also supplies the usable left and right tap bounds.

From the set of markers that were seen, the block selects one of six window shapes. It takes the midpoint of the two taps that bound that shape. Where the window found is displaced by a quarter cycle or a half cycle, it removes that offset, measured in taps. The result is clamped into the legal range.

A one-cycle start pulse launches the calculation. Two clock edges later the block presents a registered tap together with a one-cycle done pulse and an error flag. A set of flags that fits no shape raises the error flag and keeps the previous tap.

Top module: `dqs_center_calc`

## Requirements
- R1: While rst_n is low, and after its release until the first result, tap_o is 0, err_o is 0 and done_o is 0.
- R2: A start_i level high at clock edge N captures all inputs at that edge. done_o is then high for exactly one cycle after edge N+1. tap_o and err_o change only at that edge. Input changes after edge N do not affect the result.
- R3: If noise-to-zero and zero-to-noise are both found and half-cycle-to-noise is not found, the tap is floor((ftz_tap + ztf_tap)/2). This case takes priority over every other case.
- R4: Otherwise, if zero-to-noise and noise-to-half are both found, the tap is floor((ztf_tap + fth_tap)/2) - TAPS_PER_90.
- R5: Otherwise, if noise-to-half and half-to-noise are both found and zero-to-noise is not found, the tap is floor((fth_tap + htf_tap)/2) - 2*TAPS_PER_90.
- R6: If only noise-to-zero is found, the tap is floor((ftz_tap + right_lim)/2).
- R7: If only zero-to-noise is found, the tap is floor((left_lim + ztf_tap)/2).
- R8: If only noise-to-half is found, the tap is floor((fth_tap + right_lim)/2) - 2*TAPS_PER_90.
- R9: A computed value below 0 is output as 0. A computed value above right_lim is output as right_lim.
- R10: A flag set matching none of R3 to R8 gives err_o = 1 with the done pulse, and tap_o keeps its previous value. The next matching result clears err_o to 0.
- R11: When noise-to-zero, zero-to-noise and noise-to-half are all found and half-to-noise is not, the R3 formula is used and the R4 formula is not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to compute |
| ftz_found_i | input | 1 | Noise-to-zero edge seen |
| ftz_tap_i | input | TAP_W | Noise-to-zero edge tap |
| ztf_found_i | input | 1 | Zero-to-noise edge seen |
| ztf_tap_i | input | TAP_W | Zero-to-noise edge tap |
| fth_found_i | input | 1 | Noise-to-half-cycle edge seen |
| fth_tap_i | input | TAP_W | Noise-to-half-cycle edge tap |
| htf_found_i | input | 1 | Half-cycle-to-noise edge seen |
| htf_tap_i | input | TAP_W | Half-cycle-to-noise edge tap |
| left_lim_i | input | TAP_W | Lowest usable tap |
| right_lim_i | input | TAP_W | Highest usable tap |
| done_o | output | 1 | One-cycle result pulse |
| err_o | output | 1 | Last request matched no case |
| tap_o | output | TAP_W | Centered target tap |

## Verification
Each of the six window shapes is driven with distinct tap values. A result that used the wrong operand pair or the wrong quarter-cycle offset would therefore give a different number. A flag set where the first two shapes overlap tells the priority order apart. Underflow and overflow stimuli separate clamping at zero from clamping at the right bound. Empty and lone half-to-noise flag sets are followed by a valid request, which shows that the tap is held on error and that the error flag clears afterwards. A change to the inputs right after start confirms that the values are captured on the start edge.

// File: rtl/dqs_center_pkg.sv
package dqs_center_pkg;
    typedef enum logic [2:0] {
        CS_NONE     = 3'd0,
        CS_PAIR_LOW = 3'd1,
        CS_QUARTER  = 3'd2,
        CS_HALF     = 3'd3,
        CS_ONLY_FTZ = 3'd4,
        CS_ONLY_ZTF = 3'd5,
        CS_ONLY_FTH = 3'd6
    } win_case_e;
endpackage

// File: rtl/dqs_case_sel.sv
module dqs_case_sel
    import dqs_center_pkg::*;
(
    input  logic      ftz_i,
    input  logic      ztf_i,
    input  logic      fth_i,
    input  logic      htf_i,
    output win_case_e case_o
);
    logic [3:0] flags;
    assign flags = {ftz_i, ztf_i, fth_i, htf_i};

    always_comb begin
        if (ftz_i && ztf_i && !htf_i)       case_o = CS_PAIR_LOW;
        else if (ztf_i && fth_i)            case_o = CS_QUARTER;
        else if (fth_i && htf_i && !ztf_i)  case_o = CS_HALF;
        else if (flags == 4'b1000)          case_o = CS_ONLY_FTZ;
        else if (flags == 4'b0100)          case_o = CS_ONLY_ZTF;
        else if (flags == 4'b0010)          case_o = CS_ONLY_FTH;
        else                                case_o = CS_NONE;
    end
endmodule

// File: rtl/dqs_mid_calc.sv
module dqs_mid_calc
    import dqs_center_pkg::*;
#(
    parameter int TAP_W = 6
) (
    input  win_case_e          case_i,
    input  logic [TAP_W-1:0]   ftz_tap_i,
    input  logic [TAP_W-1:0]   ztf_tap_i,
    input  logic [TAP_W-1:0]   fth_tap_i,
    input  logic [TAP_W-1:0]   htf_tap_i,
    input  logic [TAP_W-1:0]   left_i,
    input  logic [TAP_W-1:0]   right_i,
    output logic [TAP_W-1:0]   mid_o,
    output logic [1:0]         quarters_o,
    output logic               err_o
);
    logic [TAP_W-1:0] op_a, op_b;
    logic [TAP_W:0]   sum;

    always_comb begin
        op_a       = '0;
        op_b       = '0;
        quarters_o = 2'd0;
        err_o      = 1'b0;
        unique case (case_i)
            CS_PAIR_LOW: begin op_a = ftz_tap_i; op_b = ztf_tap_i; end
            CS_QUARTER:  begin op_a = ztf_tap_i; op_b = fth_tap_i; quarters_o = 2'd1; end
            CS_HALF:     begin op_a = fth_tap_i; op_b = htf_tap_i; quarters_o = 2'd2; end
            CS_ONLY_FTZ: begin op_a = ftz_tap_i; op_b = right_i; end
            CS_ONLY_ZTF: begin op_a = left_i;    op_b = ztf_tap_i; end
            CS_ONLY_FTH: begin op_a = fth_tap_i; op_b = right_i;   quarters_o = 2'd2; end
            default:     err_o = 1'b1;
        endcase
    end

    assign sum   = {1'b0, op_a} + {1'b0, op_b};
    assign mid_o = sum[TAP_W:1];
endmodule

// File: rtl/dqs_offset_sat.sv
module dqs_offset_sat #(
    parameter int TAP_W       = 6,
    parameter int TAPS_PER_90 = 10
) (
    input  logic [TAP_W-1:0] mid_i,
    input  logic [1:0]       quarters_i,
    input  logic [TAP_W-1:0] right_i,
    output logic [TAP_W-1:0] tap_o
);
    localparam int HALF_TAPS = 2 * TAPS_PER_90;

    always_comb begin
        int off;
        int diff;
        case (quarters_i)
            2'd1:    off = TAPS_PER_90;
            2'd2:    off = HALF_TAPS;
            default: off = 0;
        endcase
        diff = int'(mid_i) - off;
        if (diff < 0)                 tap_o = '0;
        else if (diff > int'(right_i)) tap_o = right_i;
        else                          tap_o = diff[TAP_W-1:0];
    end
endmodule

// File: rtl/dqs_center_calc.sv
module dqs_center_calc
    import dqs_center_pkg::*;
#(
    parameter int TAP_W       = 6,
    parameter int TAPS_PER_90 = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ftz_found_i,
    input  logic [TAP_W-1:0] ftz_tap_i,
    input  logic             ztf_found_i,
    input  logic [TAP_W-1:0] ztf_tap_i,
    input  logic             fth_found_i,
    input  logic [TAP_W-1:0] fth_tap_i,
    input  logic             htf_found_i,
    input  logic [TAP_W-1:0] htf_tap_i,
    input  logic [TAP_W-1:0] left_lim_i,
    input  logic [TAP_W-1:0] right_lim_i,
    output logic             done_o,
    output logic             err_o,
    output logic [TAP_W-1:0] tap_o
);
    typedef struct packed {
        logic             s1_vld;
        logic             s1_err;
        logic [TAP_W-1:0] s1_mid;
        logic [1:0]       s1_qtr;
        logic [TAP_W-1:0] s1_right;
        logic             done;
        logic             err;
        logic [TAP_W-1:0] tap;
    } calc_state_t;

    calc_state_t st_d, st_q;

    win_case_e        sel_case;
    logic [TAP_W-1:0] mid_val;
    logic [1:0]       mid_qtr;
    logic             mid_err;
    logic [TAP_W-1:0] sat_tap;

    dqs_case_sel u_case_sel (
        .ftz_i  (ftz_found_i),
        .ztf_i  (ztf_found_i),
        .fth_i  (fth_found_i),
        .htf_i  (htf_found_i),
        .case_o (sel_case)
    );

    dqs_mid_calc #(.TAP_W(TAP_W)) u_mid_calc (
        .case_i     (sel_case),
        .ftz_tap_i  (ftz_tap_i),
        .ztf_tap_i  (ztf_tap_i),
        .fth_tap_i  (fth_tap_i),
        .htf_tap_i  (htf_tap_i),
        .left_i     (left_lim_i),
        .right_i    (right_lim_i),
        .mid_o      (mid_val),
        .quarters_o (mid_qtr),
        .err_o      (mid_err)
    );

    dqs_offset_sat #(.TAP_W(TAP_W), .TAPS_PER_90(TAPS_PER_90)) u_offset_sat (
        .mid_i      (st_q.s1_mid),
        .quarters_i (st_q.s1_qtr),
        .right_i    (st_q.s1_right),
        .tap_o      (sat_tap)
    );

    always_comb begin
        st_d        = st_q;
        st_d.s1_vld = start_i;
        st_d.done   = 1'b0;
        if (start_i) begin
            st_d.s1_err   = mid_err;
            st_d.s1_mid   = mid_val;
            st_d.s1_qtr   = mid_qtr;
            st_d.s1_right = right_lim_i;
        end
        if (st_q.s1_vld) begin
            st_d.done = 1'b1;
            st_d.err  = st_q.s1_err;
            if (!st_q.s1_err) st_d.tap = sat_tap;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;
    assign err_o  = st_q.err;
    assign tap_o  = st_q.tap;
endmodule

// File: rtl/dqs_center_calc_chk.sv
module dqs_center_calc_chk #(
    parameter int TAP_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             ftz_found_i,
    input logic             ztf_found_i,
    input logic             fth_found_i,
    input logic             htf_found_i,
    input logic [TAP_W-1:0] right_lim_i,
    input logic             done_o,
    input logic             err_o,
    input logic [TAP_W-1:0] tap_o
);
    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> ##1 done_o); // R2

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(tap_o) && $stable(err_o))); // R2

    AST_TAP_WITHIN_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (tap_o <= $past(right_lim_i, 2))); // R9

    AST_ERR_KEEPS_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> $stable(tap_o)); // R10

    AST_EMPTY_FLAGS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !ftz_found_i && !ztf_found_i && !fth_found_i && !htf_found_i)
        |=> ##1 err_o); // R10
endmodule

bind dqs_center_calc dqs_center_calc_chk #(.TAP_W(TAP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .ftz_found_i (ftz_found_i),
    .ztf_found_i (ztf_found_i),
    .fth_found_i (fth_found_i),
    .htf_found_i (htf_found_i),
    .right_lim_i (right_lim_i),
    .done_o      (done_o),
    .err_o       (err_o),
    .tap_o       (tap_o)
);

// File: tb/dqs_center_calc_bench.sv
module dqs_center_calc_bench;
    localparam int TAP_W = 6;
    localparam int TP90  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic ftz_f = 1'b0, ztf_f = 1'b0, fth_f = 1'b0, htf_f = 1'b0;
    logic [TAP_W-1:0] ftz_t = '0, ztf_t = '0, fth_t = '0, htf_t = '0;
    logic [TAP_W-1:0] left_l = '0, right_l = 6'd63;
    logic done_o, err_o;
    logic [TAP_W-1:0] tap_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dqs_center_calc #(.TAP_W(TAP_W), .TAPS_PER_90(TP90)) u_dqs_center_calc (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .ftz_found_i(ftz_f), .ftz_tap_i(ftz_t),
        .ztf_found_i(ztf_f), .ztf_tap_i(ztf_t),
        .fth_found_i(fth_f), .fth_tap_i(fth_t),
        .htf_found_i(htf_f), .htf_tap_i(htf_t),
        .left_lim_i(left_l), .right_lim_i(right_l),
        .done_o(done_o), .err_o(err_o), .tap_o(tap_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_in(input logic [3:0] fl, input int a, input int b,
                          input int c, input int d, input int l, input int r);
        {ftz_f, ztf_f, fth_f, htf_f} = fl;
        ftz_t = a[TAP_W-1:0]; ztf_t = b[TAP_W-1:0];
        fth_t = c[TAP_W-1:0]; htf_t = d[TAP_W-1:0];
        left_l = l[TAP_W-1:0]; right_l = r[TAP_W-1:0];
    endtask

    // Launch a request and check the result at the done cycle.
    task automatic run(input string req, input logic [3:0] fl, input int a, input int b,
                       input int c, input int d, input int l, input int r,
                       input int exp_tap, input int exp_err);
        @(negedge clk);
        set_in(fl, a, b, c, d, l, r);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check({req, " done not early"}, int'(done_o), 0);
        @(negedge clk);
        check({req, " done"}, int'(done_o), 1);
        check({req, " tap"}, int'(tap_o), exp_tap);
        check({req, " err"}, int'(err_o), exp_err);
    endtask

    task automatic t_reset;
        check("R1 tap", int'(tap_o), 0);
        check("R1 err", int'(err_o), 0);
        check("R1 done", int'(done_o), 0);
    endtask

    task automatic t_pair_low;   run("R3", 4'b1100, 20, 45, 0, 0, 0, 63, 32, 0); endtask
    task automatic t_quarter;    run("R4", 4'b0110, 0, 30, 57, 0, 0, 63, 33, 0); endtask
    task automatic t_half;       run("R5", 4'b0011, 0, 0, 40, 61, 0, 63, 30, 0); endtask
    task automatic t_only_ftz;   run("R6", 4'b1000, 40, 0, 0, 0, 0, 60, 50, 0); endtask
    task automatic t_only_ztf;   run("R7", 4'b0100, 0, 19, 0, 0, 4, 63, 11, 0); endtask
    task automatic t_only_fth;   run("R8", 4'b0010, 0, 0, 50, 0, 0, 62, 36, 0); endtask
    task automatic t_priority;   run("R11", 4'b1110, 10, 30, 50, 0, 0, 63, 20, 0); endtask

    task automatic t_saturate;
        run("R9 low", 4'b0010, 0, 0, 10, 0, 0, 20, 0, 0);
        run("R9 high", 4'b1000, 63, 0, 0, 0, 0, 40, 40, 0);
    endtask

    task automatic t_error;
        run("R10 empty", 4'b0000, 5, 5, 5, 5, 0, 63, 40, 1);
        run("R10 lone htf", 4'b0001, 0, 0, 0, 30, 0, 63, 40, 1);
        run("R10 clear", 4'b0100, 0, 20, 0, 0, 10, 63, 15, 0);
    endtask

    task automatic t_timing;
        // Inputs changed after the start edge must not alter the result.
        @(negedge clk);
        set_in(4'b1100, 10, 20, 0, 0, 0, 63);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        set_in(4'b1000, 60, 0, 0, 0, 0, 63);
        @(negedge clk);
        check("R2 done", int'(done_o), 1);
        check("R2 captured tap", int'(tap_o), 15);
        @(negedge clk);
        check("R2 single pulse", int'(done_o), 0);
        check("R2 tap held", int'(tap_o), 15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pair_low();
        t_quarter();
        t_half();
        t_only_ftz();
        t_only_ztf();
        t_only_fth();
        t_priority();
        t_saturate();
        t_error();
        t_timing();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule